// File: doc/BRIEF.md
# Bus-Hold Test-and-Set Sequencer

This block performs an atomic test-and-set or clear on one word of shared memory across a multi-master backplane whose slaves cannot handle an indivisible read-modify-write cycle. Atomicity comes from bus ownership. The sequencer requests the bus and waits for the grant. It then keeps the request asserted across a separate read cycle and write cycle, and releases the bus only after the last cycle has finished. No other master can reach the lock word in between.

Software presents a request with an address and an operation: set or clear. On a set, the word is read first. If the lock bit is already high, nothing is written and the result reports that the lock is held. Otherwise the word is written back with the lock bit raised, and the result reports success. A clear writes the unlocked value under the same bus ownership and does no read. A bus error on either cycle ends the sequence at once and releases the bus. Every bus cycle the block issues is marked as non-cacheable. The board that hosts the shared memory uses this same block for its own accesses to the lock word.

Top module: `tas_lock_seq`

## Requirements
- R1: After a synchronous reset, `busy`, `done`, `bus_req` and `bus_cyc` are all low.
- R2: A request (`op_valid` high while `busy` is low) is accepted at the clock edge. From the next cycle, `busy` and `bus_req` are both high.
- R3: A bus cycle (`bus_cyc` high) starts only in the cycle after `bus_grant` was sampled high. While the grant is withheld, `bus_cyc` stays low and `bus_req` stays high.
- R4: `bus_req` stays high without a gap from acceptance through the final acknowledge, the skipped write, or the error. It is high in every cycle where `bus_cyc` is high, and it falls only together with `done`.
- R5: A set (`op_kind`=0) on a word whose lock bit (bit 7 by default) is low issues one read and then one write of the read value with the lock bit raised. It reports `result`=0 (success).
- R6: A set on a word whose lock bit is high issues one read and no write, and reports `result`=1 (held).
- R7: A clear (`op_kind`=1) issues no read and one write of the unlocked value (0 by default). It reports `result`=0.
- R8: A bus error (`bus_err`) on the read or the write ends the sequence at the next edge. After that edge, `bus_cyc` and `bus_req` are low and `done` is high with `result`=2. No further cycle is issued.
- R9: `bus_nocache` is high in every cycle where `bus_cyc` is high.
- R10: `op_valid` is ignored while `busy` is high. No second sequence runs, and memory is not touched at the other address.
- R11: `done` is a one-cycle pulse, and `busy` is low in the cycle where `done` is high. A request presented in that cycle is accepted.
- R12: `bus_addr` equals the accepted `op_addr` and stays stable while `bus_cyc` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Request strobe from software |
| op_kind | input | 1 | 0 = test-and-set, 1 = clear |
| op_addr | input | AW | Address of the lock word |
| busy | output | 1 | Sequence in progress; new requests ignored |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 success, 1 lock already held, 2 bus error |
| bus_req | output | 1 | Bus ownership request |
| bus_grant | input | 1 | Bus ownership grant |
| bus_cyc | output | 1 | Bus cycle active |
| bus_we | output | 1 | Bus cycle is a write |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Write data |
| bus_nocache | output | 1 | Marks the cycle as non-cacheable |
| bus_rdata | input | DW | Read data |
| bus_ack | input | 1 | Cycle acknowledge |
| bus_err | input | 1 | Cycle bus error |

## Verification
Two events can meet at the edge where a sequence ends: completion, which drops `busy` and pulses `done`, and the acceptance of the next software request. The bench provokes this in two ways. First, it presents a clear during the final write cycle, while `busy` is still high. That request must be dropped. Second, it presents a request in exactly the cycle where `done` is high. That request must start a fresh sequence at once. The bench judges the outcome from the done pulse count, the `busy` and `done` levels one cycle later, and the contents of the memory model.

// File: rtl/tas_pkg.sv
package tas_pkg;
  typedef enum logic [1:0] {
    RES_OK     = 2'd0,
    RES_HELD   = 2'd1,
    RES_BUSERR = 2'd2
  } tas_result_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_REQ   = 2'd1,
    SQ_READ  = 2'd2,
    SQ_WRITE = 2'd3
  } tas_state_e;

  localparam logic KIND_SET   = 1'b0;
  localparam logic KIND_CLEAR = 1'b1;
endpackage

// File: rtl/tas_req_latch.sv
module tas_req_latch #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_valid,
  input  logic          op_kind,
  input  logic [AW-1:0] op_addr,
  input  logic          fin_evt,
  output logic          accept,
  output logic          busy,
  output logic          kind_q,
  output logic [AW-1:0] addr_q
);
  assign accept = op_valid && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      kind_q <= 1'b0;
      addr_q <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      kind_q <= op_kind;
      addr_q <= op_addr;
    end else if (fin_evt) begin
      busy   <= 1'b0;
    end
  end
endmodule

// File: rtl/tas_seq_fsm.sv
module tas_seq_fsm
  import tas_pkg::*;
#(
  parameter int          AW              = 16,
  parameter int          DW              = 8,
  parameter int          LOCK_BIT        = 7,
  parameter logic [DW-1:0] UNLOCK_VAL    = '0,
  parameter bit          SET_KEEP_OTHERS = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic          kind_q,
  input  logic [AW-1:0] addr_q,
  input  logic          bus_grant,
  input  logic          bus_ack,
  input  logic          bus_err,
  input  logic [DW-1:0] bus_rdata,
  output logic          bus_req,
  output logic          bus_cyc,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_nocache,
  output logic          fin_evt,
  output tas_result_e   fin_code
);
  localparam logic [DW-1:0] LOCK_MASK = DW'(1) << LOCK_BIT;

  tas_state_e   state;
  logic [DW-1:0] set_value;
  logic          word_held;

  assign word_held = bus_rdata[LOCK_BIT];

  generate
    if (SET_KEEP_OTHERS) begin : g_keep
      assign set_value = bus_rdata | LOCK_MASK;
    end else begin : g_mask_only
      assign set_value = LOCK_MASK;
    end
  endgenerate

  always_comb begin
    fin_evt  = 1'b0;
    fin_code = RES_OK;
    case (state)
      SQ_READ: begin
        if (bus_err) begin
          fin_evt  = 1'b1;
          fin_code = RES_BUSERR;
        end else if (bus_ack && word_held) begin
          fin_evt  = 1'b1;
          fin_code = RES_HELD;
        end
      end
      SQ_WRITE: begin
        if (bus_err) begin
          fin_evt  = 1'b1;
          fin_code = RES_BUSERR;
        end else if (bus_ack) begin
          fin_evt  = 1'b1;
          fin_code = RES_OK;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= SQ_IDLE;
      bus_req     <= 1'b0;
      bus_cyc     <= 1'b0;
      bus_we      <= 1'b0;
      bus_addr    <= '0;
      bus_wdata   <= '0;
      bus_nocache <= 1'b0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (accept) begin
            state   <= SQ_REQ;
            bus_req <= 1'b1;
          end
        end
        SQ_REQ: begin
          if (bus_grant) begin
            bus_cyc     <= 1'b1;
            bus_nocache <= 1'b1;
            bus_addr    <= addr_q;
            if (kind_q == KIND_CLEAR) begin
              state     <= SQ_WRITE;
              bus_we    <= 1'b1;
              bus_wdata <= UNLOCK_VAL;
            end else begin
              state     <= SQ_READ;
              bus_we    <= 1'b0;
            end
          end
        end
        SQ_READ: begin
          if (fin_evt) begin
            state       <= SQ_IDLE;
            bus_req     <= 1'b0;
            bus_cyc     <= 1'b0;
            bus_nocache <= 1'b0;
          end else if (bus_ack) begin
            state     <= SQ_WRITE;
            bus_we    <= 1'b1;
            bus_wdata <= set_value;
          end
        end
        SQ_WRITE: begin
          if (fin_evt) begin
            state       <= SQ_IDLE;
            bus_req     <= 1'b0;
            bus_cyc     <= 1'b0;
            bus_we      <= 1'b0;
            bus_nocache <= 1'b0;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tas_result_reg.sv
module tas_result_reg
  import tas_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        fin_evt,
  input  tas_result_e fin_code,
  output logic        done,
  output logic [1:0]  result
);
  always_ff @(posedge clk) begin
    if (rst) begin
      done   <= 1'b0;
      result <= 2'd0;
    end else begin
      done <= fin_evt;
      if (fin_evt) result <= fin_code;
    end
  end
endmodule

// File: rtl/tas_lock_seq.sv
module tas_lock_seq
  import tas_pkg::*;
#(
  parameter int            AW              = 16,
  parameter int            DW              = 8,
  parameter int            LOCK_BIT        = 7,
  parameter logic [DW-1:0] UNLOCK_VAL      = '0,
  parameter bit            SET_KEEP_OTHERS = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_valid,
  input  logic          op_kind,
  input  logic [AW-1:0] op_addr,
  output logic          busy,
  output logic          done,
  output logic [1:0]    result,
  output logic          bus_req,
  input  logic          bus_grant,
  output logic          bus_cyc,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_nocache,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ack,
  input  logic          bus_err
);
  logic          accept;
  logic          kind_q;
  logic [AW-1:0] addr_q;
  logic          fin_evt;
  tas_result_e   fin_code;

  tas_req_latch #(.AW(AW)) u_latch (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
    .op_addr(op_addr), .fin_evt(fin_evt), .accept(accept), .busy(busy),
    .kind_q(kind_q), .addr_q(addr_q)
  );

  tas_seq_fsm #(
    .AW(AW), .DW(DW), .LOCK_BIT(LOCK_BIT), .UNLOCK_VAL(UNLOCK_VAL),
    .SET_KEEP_OTHERS(SET_KEEP_OTHERS)
  ) u_fsm (
    .clk(clk), .rst(rst), .accept(accept), .kind_q(kind_q), .addr_q(addr_q),
    .bus_grant(bus_grant), .bus_ack(bus_ack), .bus_err(bus_err),
    .bus_rdata(bus_rdata), .bus_req(bus_req), .bus_cyc(bus_cyc),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_nocache(bus_nocache), .fin_evt(fin_evt), .fin_code(fin_code)
  );

  tas_result_reg u_res (
    .clk(clk), .rst(rst), .fin_evt(fin_evt), .fin_code(fin_code),
    .done(done), .result(result)
  );
endmodule

// File: rtl/tas_lock_seq_chk.sv
module tas_lock_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          op_valid,
  input logic          busy,
  input logic          done,
  input logic          bus_req,
  input logic          bus_grant,
  input logic          bus_cyc,
  input logic          bus_err,
  input logic [AW-1:0] bus_addr,
  input logic          bus_nocache
);
  p_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !busy) |=> (busy && bus_req));

  p_grant_first_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_cyc) |-> $past(bus_grant));

  p_req_covers_cyc_r4: assert property (@(posedge clk) disable iff (rst)
    bus_cyc |-> bus_req);

  p_req_release_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_req) |-> done);

  p_err_abort_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_cyc && bus_err) |=> (!bus_cyc && !bus_req && done));

  p_nocache_r9: assert property (@(posedge clk) disable iff (rst)
    bus_cyc |-> bus_nocache);

  p_done_free_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_addr_stable_r12: assert property (@(posedge clk) disable iff (rst)
    (bus_cyc && $past(bus_cyc)) |-> $stable(bus_addr));
endmodule

bind tas_lock_seq tas_lock_seq_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst(rst), .op_valid(op_valid), .busy(busy), .done(done),
  .bus_req(bus_req), .bus_grant(bus_grant), .bus_cyc(bus_cyc),
  .bus_err(bus_err), .bus_addr(bus_addr), .bus_nocache(bus_nocache)
);

// File: tb/tas_lock_seq_tb_top.sv
module tas_lock_seq_tb_top;
  localparam int AW = 16;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          op_valid;
  logic          op_kind;
  logic [AW-1:0] op_addr;
  logic          busy, done;
  logic [1:0]    result;
  logic          bus_req, bus_grant, bus_cyc, bus_we, bus_nocache;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic          bus_ack, bus_err;

  logic          grant_allow;
  int            err_mode;
  logic [DW-1:0] mem [16];
  int            rd_cnt, wr_cnt, done_cnt, nocache_bad, addr_bad;
  logic [AW-1:0] exp_addr;
  int            checks, errors;

  always #2.5 clk = ~clk;

  tas_lock_seq dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
    .op_addr(op_addr), .busy(busy), .done(done), .result(result),
    .bus_req(bus_req), .bus_grant(bus_grant), .bus_cyc(bus_cyc),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_nocache(bus_nocache), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .bus_err(bus_err)
  );

  assign bus_grant = bus_req && grant_allow;
  assign bus_err   = bus_cyc && ((err_mode == 1 && !bus_we) || (err_mode == 2 && bus_we));
  assign bus_ack   = bus_cyc && !bus_err;
  assign bus_rdata = mem[bus_addr[3:0]];

  always @(posedge clk) begin
    if (bus_cyc && bus_ack) begin
      if (bus_we) begin
        mem[bus_addr[3:0]] <= bus_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        rd_cnt <= rd_cnt + 1;
      end
    end
    if (done) done_cnt <= done_cnt + 1;
    if (bus_cyc && !bus_nocache) nocache_bad <= nocache_bad + 1;
    if (bus_cyc && bus_addr != exp_addr) addr_bad <= addr_bad + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic issue(input logic kind, input logic [AW-1:0] a);
    @(negedge clk);
    op_valid = 1'b1; op_kind = kind; op_addr = a; exp_addr = a;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk(done == 1'b1, "R4 done seen", int'(done), 1);
  endtask

  task automatic clear_counts();
    @(negedge clk);
    rd_cnt = 0; wr_cnt = 0; done_cnt = 0;
  endtask

  task automatic t_reset();
    chk(!busy && !done && !bus_req && !bus_cyc, "R1 reset state",
        int'({busy, done, bus_req, bus_cyc}), 0);
  endtask

  task automatic t_set_free(input logic [3:0] a, input logic [DW-1:0] init);
    clear_counts();
    mem[a] = init;
    issue(1'b0, AW'(a));
    chk(busy && bus_req, "R2 busy and request after accept", int'({busy, bus_req}), 3);
    wait_done();
    chk(result == 2'd0, "R5 set free result", result, 0);
    @(negedge clk);
    chk(mem[a] == (init | 8'h80), "R5 lock word written", mem[a], init | 8'h80);
    chk(rd_cnt == 1 && wr_cnt == 1, "R5 one read one write", rd_cnt * 10 + wr_cnt, 11);
    chk(!done, "R11 done lasts one cycle", int'(done), 0);
  endtask

  task automatic t_set_held();
    clear_counts();
    mem[3] = 8'h81;
    issue(1'b0, 16'd3);
    wait_done();
    chk(result == 2'd1, "R6 held result", result, 1);
    @(negedge clk);
    chk(wr_cnt == 0 && rd_cnt == 1, "R6 read only", rd_cnt * 10 + wr_cnt, 10);
    chk(mem[3] == 8'h81, "R6 word untouched", mem[3], 8'h81);
  endtask

  task automatic t_clear();
    clear_counts();
    mem[3] = 8'h85;
    issue(1'b1, 16'd3);
    wait_done();
    chk(result == 2'd0, "R7 clear result", result, 0);
    @(negedge clk);
    chk(mem[3] == 8'h00, "R7 unlocked value", mem[3], 0);
    chk(rd_cnt == 0 && wr_cnt == 1, "R7 write only", rd_cnt * 10 + wr_cnt, 1);
  endtask

  task automatic t_grant_delay();
    clear_counts();
    mem[9] = 8'h00;
    grant_allow = 1'b0;
    issue(1'b0, 16'd9);
    for (int i = 0; i < 5; i++) begin
      chk(!bus_cyc && bus_req, "R3 no cycle without grant", int'({bus_req, bus_cyc}), 2);
      @(negedge clk);
    end
    grant_allow = 1'b1;
    wait_done();
    chk(result == 2'd0, "R3 completes after grant", result, 0);
    @(negedge clk);
    chk(mem[9] == 8'h80, "R3 word set after grant", mem[9], 8'h80);
  endtask

  task automatic t_error(input int mode);
    clear_counts();
    mem[4] = 8'h00;
    err_mode = mode;
    issue(1'b0, 16'd4);
    wait_done();
    chk(result == 2'd2, "R8 error result", result, 2);
    chk(!bus_req && !bus_cyc, "R8 bus released", int'({bus_req, bus_cyc}), 0);
    err_mode = 0;
    repeat (3) @(negedge clk);
    chk(mem[4] == 8'h00 && wr_cnt == 0, "R8 no write after error", mem[4], 0);
    chk(!bus_cyc && done_cnt == 1, "R8 no further cycle", done_cnt, 1);
  endtask

  task automatic t_busy_block();
    clear_counts();
    mem[7] = 8'h00; mem[8] = 8'h80;
    issue(1'b0, 16'd7);
    op_valid = 1'b1; op_kind = 1'b1; op_addr = 16'd8;
    while (!(bus_cyc && bus_we)) @(negedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    wait_done();
    repeat (4) @(negedge clk);
    chk(done_cnt == 1, "R10 only one sequence", done_cnt, 1);
    chk(mem[8] == 8'h80, "R10 other word untouched", mem[8], 8'h80);
    chk(mem[7] == 8'h80, "R10 first request served", mem[7], 8'h80);
  endtask

  task automatic t_back_to_back();
    clear_counts();
    mem[6] = 8'h00;
    issue(1'b0, 16'd6);
    wait_done();
    chk(!busy, "R11 not busy while done", int'(busy), 0);
    op_valid = 1'b1; op_kind = 1'b1; op_addr = 16'd6; exp_addr = 16'd6;
    @(negedge clk);
    op_valid = 1'b0;
    chk(busy && !done, "R11 request in done cycle accepted", int'({busy, done}), 2);
    wait_done();
    @(negedge clk);
    chk(done_cnt == 2, "R11 two sequences", done_cnt, 2);
    chk(mem[6] == 8'h00, "R11 second op cleared word", mem[6], 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    rst = 1'b1; op_valid = 1'b0; op_kind = 1'b0; op_addr = '0; exp_addr = '0;
    grant_allow = 1'b1; err_mode = 0;
    rd_cnt = 0; wr_cnt = 0; done_cnt = 0; nocache_bad = 0; addr_bad = 0;
    for (int i = 0; i < 16; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_set_free(4'd3, 8'h00);
    t_set_free(4'd5, 8'h12);
    t_set_held();
    t_clear();
    t_grant_delay();
    t_error(1);
    t_error(2);
    t_busy_block();
    t_back_to_back();
    chk(nocache_bad == 0, "R9 non-cacheable marking", nocache_bad, 0);
    chk(addr_bad == 0, "R12 bus address matches request", addr_bad, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule